// File: doc/BRIEF.md
# Serial-Bus Clock Output-Enable Register Slave

This block is a two-wire bus slave (SMBus, standard mode) that holds a small bank of clock output-enable registers. It watches the bus clock and data lines, answers only its own 7-bit device address, and accepts both write and read transfers. Every register bit drives one enable. A cleared bit holds the matching gated clock output at a static logic low. At reset every enable is set, so all outputs start running.

The registers cannot be addressed one at a time. A write transfer carries these bytes in order:

1. The address with the write bit.
2. A command byte, which is acknowledged and then ignored.
3. A byte count, which is acknowledged and then ignored.
4. Data bytes, which fill register 0, then register 1, and so on.

A read transfer returns a count byte first, then every register in index order.

Both bus lines are first cleaned on the system clock by a two-flop synchronizer and a stability filter. START, STOP and the clock edges are then found on the cleaned lines. The block drives data only by pulling it low, and the line idles high through its pull-up. The bus carries its own flow control, so the block has no valid/ready interface. Back-pressure does not arise: the slave never stretches the clock and keeps up with every byte.

Top module: `smb_oe_slave`

## Requirements
- R1: After reset, every bit of `en_o` is 1, `sda_oe_o` is 0 (bus released) and `out_o` equals `src_i`.
- R2: The slave pulls SDA low in the acknowledge slot of the first byte after START only when bits 7:1 of that byte equal parameter `ADDR`. For any other address it does not acknowledge, and it ignores the bus until the next START, leaving `en_o` unchanged.
- R3: In a write transfer (address byte bit 0 = 0), the two bytes after the address are acknowledged and have no effect. Data byte k then loads register k, starting at k = 0, and register k drives `en_o[8k+7:8k]`. A transfer with fewer data bytes leaves the later registers unchanged.
- R4: Write data bytes beyond the seventh are acknowledged and discarded.
- R5: In a read transfer (address byte bit 0 = 1), the slave sends the value 7 first, then registers 0 through 6 in order, most significant bit first.
- R6: The slave only ever pulls SDA low, and only changes its drive after a falling SCL edge. It releases SDA when the master does not acknowledge a read byte, at STOP, and whenever it is idle.
- R7: A START or repeated START at any point returns the byte sequencer to the address phase, so the next byte is decoded as a device address.
- R8: A register changes only when the SCL falling edge that closes the acknowledge slot of its data byte is seen. `en_o` never changes while a byte is still being shifted in.
- R9: `out_o[i]` follows `src_i[i]` while `en_o[i]` is 1 and is held at 0 while `en_o[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| src_i | input | NREG*8 | Free-running clocks to be gated |
| en_o | output | NREG*8 | Enable bits, register k in bits 8k+7:8k |
| out_o | output | NREG*8 | Gated clocks, low when disabled |

## Verification
The bench probes several corner cases, each of which would expose a specific fault:

- **Foreign address.** A slave that answered every address would acknowledge it and overwrite the enables.
- **Overlong write.** A nine-byte write catches an index that wraps, which would clobber register 0 with the eighth byte.
- **Short write.** A two-byte write catches a sequencer that clears the registers it never reached.
- **Repeated START mid-write.** A sequencer that ignored the repeated START would treat the new address as data.
- **Read terminated by the master.** The master refuses the count byte, and a slave that kept transmitting would still be pulling SDA low afterwards.
- **Enables sampled before the acknowledge closes.** This catches registers that update as soon as eight bits arrive.

// File: rtl/smb_oe_pkg.sv
package smb_oe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_WDAT,
    PH_RDAT
  } phase_t;
endpackage

// File: rtl/smb_oe_filt.sv
// Synchronizer plus stability filter for one bus line.
module smb_oe_filt #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC-1:0] sy;
  logic [FILT-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '1;
      hist <= '1;
      dout <= 1'b1;
    end else begin
      sy   <= {sy[SYNC-2:0], din};
      hist <= {hist[FILT-2:0], sy[SYNC-1]};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_oe_cond.sv
// Bus condition and edge detector on the cleaned lines.
module smb_oe_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_p = scl & scl_q & sda_q & ~sda;
  assign stop_p  = scl & scl_q & ~sda_q & sda;
  assign rise_p  = scl & ~scl_q;
  assign fall_p  = ~scl & scl_q;
endmodule

// File: rtl/smb_oe_engine.sv
// Byte sequencer and enable register bank.
module smb_oe_engine
  import smb_oe_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'h69,
  parameter int         NREG = 7,
  localparam int        NBIT = NREG * 8,
  localparam int        IW   = $clog2(NREG + 2),
  localparam int        RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda,
  input  logic            start_p,
  input  logic            stop_p,
  input  logic            rise_p,
  input  logic            fall_p,
  output logic [NBIT-1:0] en_o,
  output logic            sda_oe,
  output phase_t          phase_o,
  output logic [3:0]      bitcnt_o
);
  localparam logic [IW-1:0] NREG_I = IW'(NREG);

  phase_t                 phase;
  logic [3:0]             bitcnt;
  logic [7:0]             rxsh, txsh;
  logic [IW-1:0]          idx;
  logic                   nak;
  logic [NREG-1:0][7:0]   regf;

  // Index 0 is the count byte, 1..NREG the registers, above that all ones.
  function automatic logic [7:0] pick(input logic [IW-1:0] i,
                                      input logic [NREG-1:0][7:0] rf);
    logic [IW-1:0] j;
    j = i - IW'(1);
    if (i == '0)         pick = 8'(NREG);
    else if (i <= NREG_I) pick = rf[j[RW-1:0]];
    else                 pick = 8'hFF;
  endfunction

  logic [7:0] nxt_byte;
  assign nxt_byte = pick(idx, regf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      rxsh   <= '0;
      txsh   <= '0;
      idx    <= '0;
      nak    <= 1'b0;
      sda_oe <= 1'b0;
      regf   <= '1;
    end else if (start_p) begin
      phase  <= PH_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (rise_p) begin
        if (bitcnt < 4'd8) begin
          rxsh <= {rxsh[6:0], sda};
          txsh <= {txsh[6:0], 1'b1};
        end else begin
          nak <= sda;
        end
        bitcnt <= bitcnt + 4'd1;
      end else if (fall_p) begin
        if (bitcnt == 4'd8) begin
          // enter acknowledge slot
          if (phase == PH_ADDR)      sda_oe <= (rxsh[7:1] == ADDR);
          else if (phase == PH_RDAT) sda_oe <= 1'b0;
          else                       sda_oe <= 1'b1;
        end else if (bitcnt == 4'd9) begin
          // acknowledge slot closed
          bitcnt <= '0;
          sda_oe <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (rxsh[7:1] != ADDR) begin
                phase <= PH_IDLE;
              end else if (rxsh[0]) begin
                phase  <= PH_RDAT;
                txsh   <= pick('0, regf);
                sda_oe <= ~pick('0, regf)[7];
                idx    <= IW'(1);
              end else begin
                phase <= PH_CMD;
              end
            end
            PH_CMD: phase <= PH_CNT;
            PH_CNT: begin
              phase <= PH_WDAT;
              idx   <= '0;
            end
            PH_WDAT: begin
              if (idx < NREG_I) begin
                regf[idx[RW-1:0]] <= rxsh;
                idx <= idx + IW'(1);
              end
            end
            PH_RDAT: begin
              if (nak) begin
                phase <= PH_IDLE;
              end else begin
                txsh   <= nxt_byte;
                sda_oe <= ~nxt_byte[7];
                if (idx <= NREG_I) idx <= idx + IW'(1);
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end else if (phase == PH_RDAT && bitcnt != 4'd0) begin
          sda_oe <= ~txsh[7];
        end
      end
    end
  end

  assign en_o     = regf;
  assign phase_o  = phase;
  assign bitcnt_o = bitcnt;
endmodule

// File: rtl/smb_oe_slave.sv
module smb_oe_slave
  import smb_oe_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'h69,
  parameter int         NREG = 7,
  parameter int         SYNC = 2,
  parameter int         FILT = 3,
  localparam int        NBIT = NREG * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [NBIT-1:0] src_i,
  output logic [NBIT-1:0] en_o,
  output logic [NBIT-1:0] out_o
);
  logic [1:0] raw, clean;
  logic       start_p, stop_p, rise_p, fall_p;
  phase_t     phase;
  logic [3:0] bitcnt;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_oe_filt #(.SYNC(SYNC), .FILT(FILT)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (clean[g])
    );
  end

  smb_oe_cond cond_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl    (clean[0]),
    .sda    (clean[1]),
    .start_p(start_p),
    .stop_p (stop_p),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  smb_oe_engine #(.ADDR(ADDR), .NREG(NREG)) eng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda     (clean[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .en_o    (en_o),
    .sda_oe  (sda_oe_o),
    .phase_o (phase),
    .bitcnt_o(bitcnt)
  );

  assign out_o = src_i & en_o;
endmodule

// File: rtl/smb_oe_chk.sv
module smb_oe_chk
  import smb_oe_pkg::*;
#(
  parameter int NBIT = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_p,
  input logic            stop_p,
  input logic            rise_p,
  input logic            fall_p,
  input logic            sda_oe_o,
  input logic [NBIT-1:0] en_o,
  input phase_t          phase,
  input logic [3:0]      bitcnt
);
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (phase == PH_ADDR && bitcnt == 4'd0));

  // R7
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, stop_p, rise_p, fall_p}));

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe_o);

  // R6
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(fall_p));

  // R8
  en_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o != $past(en_o)) |-> $past(fall_p));
endmodule

bind smb_oe_slave smb_oe_chk #(.NBIT(NREG * 8)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_p (start_p),
  .stop_p  (stop_p),
  .rise_p  (rise_p),
  .fall_p  (fall_p),
  .sda_oe_o(sda_oe_o),
  .en_o    (en_o),
  .phase   (phase),
  .bitcnt  (bitcnt)
);

// File: tb/smb_oe_slave_tb_top.sv
`timescale 1ns/1ps
module smb_oe_slave_tb_top;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int NREG = 7;
  localparam int NBIT = NREG * 8;
  localparam int Q = 12;

  localparam logic [NBIT-1:0] VEC [0:3] = '{
    56'h00_00_00_00_00_00_00,
    56'h7E_81_42_24_18_A5_5A,
    56'hFF_00_FF_00_FF_00_3C,
    56'h12_34_56_78_9A_BC_DE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o;
  logic [NBIT-1:0] src_i, en_o, out_o;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe_o;

  always #2 clk = ~clk;

  smb_oe_slave #(.ADDR(ADDR), .NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .src_i(src_i), .en_o(en_o), .out_o(out_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:7];
  logic [NBIT-1:0] en_pre;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1; qw(2); scl_m = 0; qw();
    end
    sda_m = 1; qw(); scl_m = 1; qw(); ack = ~sda_line; qw();
    en_pre = en_o;
    scl_m = 0; qw();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1; qw(); b[i] = sda_line; qw(); scl_m = 0;
    end
    sda_m = ~mack; qw(); scl_m = 1; qw(2); scl_m = 0; qw();
    sda_m = 1;
  endtask

  // write n data bytes from wbuf; returns ack of address and an AND of the rest
  task automatic wr_regs(input logic [6:0] a, input int n, output logic aack, output logic dack);
    logic k;
    bus_start();
    send_byte({a, 1'b0}, aack);
    dack = 1;
    if (aack) begin
      send_byte(8'h00, k); dack &= k;
      send_byte(8'(n), k); dack &= k;
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], k); dack &= k;
      end
    end
    bus_stop();
  endtask

  task automatic rd_all(output logic aack);
    bus_start();
    send_byte({ADDR, 1'b1}, aack);
    for (int i = 0; i < 8; i++) recv_byte(i != 7, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic aack, dack, k;
    logic [7:0] b;
    logic [NBIT-1:0] model;
    src_i = '1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 en", en_o, {NBIT{1'b1}});
    chk("R1 sda", sda_oe_o, 0);
    chk("R1 out", out_o, src_i);
    model = '1;

    // vector table: full writes and read-back
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < NREG; i++) wbuf[i] = VEC[v][8*i +: 8];
      bus_start();
      send_byte({ADDR, 1'b0}, aack);
      chk("R2 ack", aack, 1);
      send_byte(8'hA7, k); chk("R3 cmd ack", k, 1);
      send_byte(8'h07, k); chk("R3 cnt ack", k, 1);
      send_byte(wbuf[0], k);
      chk("R8 en before ack end", en_pre, model);
      for (int i = 1; i < NREG; i++) send_byte(wbuf[i], k);
      bus_stop();
      model = VEC[v];
      chk("R3 en", en_o, model);
      rd_all(aack);
      chk("R5 addr ack", aack, 1);
      chk("R5 count", rbuf[0], 8'd7);
      for (int i = 0; i < NREG; i++) chk("R5 reg", rbuf[i+1], model[8*i +: 8]);
    end

    // R2 foreign address
    for (int i = 0; i < NREG; i++) wbuf[i] = 8'h55;
    wr_regs(7'h2A, NREG, aack, dack);
    chk("R2 nak", aack, 0);
    chk("R2 en kept", en_o, model);

    // R3 short write
    wbuf[0] = 8'hC3; wbuf[1] = 8'h0F;
    wr_regs(ADDR, 2, aack, dack);
    model[15:0] = 16'h0FC3;
    chk("R3 short", en_o, model);

    // R4 overlong write
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    wr_regs(ADDR, 9, aack, dack);
    chk("R4 ack", dack, 1);
    for (int i = 0; i < NREG; i++) model[8*i +: 8] = 8'(8'h11 * (i + 1));
    chk("R4 en", en_o, model);

    // R7 repeated start mid-write
    bus_start();
    send_byte({ADDR, 1'b0}, aack);
    send_byte(8'h00, k); send_byte(8'h01, k);
    send_byte(8'h3E, k);
    model[7:0] = 8'h3E;
    bus_start();
    send_byte({ADDR, 1'b0}, aack);
    chk("R7 readdr ack", aack, 1);
    send_byte(8'h00, k); send_byte(8'h01, k);
    send_byte(8'h4D, k);
    bus_stop();
    model[7:0] = 8'h4D;
    chk("R7 en", en_o, model);

    // R6 master refuses the count byte; reg0 bit7 is 0 so a stuck slave would drive
    bus_start();
    send_byte({ADDR, 1'b1}, aack);
    recv_byte(1'b0, b);
    chk("R6 count", b, 8'd7);
    qw();
    chk("R6 released", sda_oe_o, 0);
    bus_stop();
    chk("R6 idle", sda_oe_o, 0);

    // R9 gating
    src_i = 56'hAAAA_5555_F0F0_0F;
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h0F;
    wr_regs(ADDR, 3, aack, dack);
    model[23:0] = 24'h0F_FF_00;
    @(negedge clk);
    chk("R9 out", out_o, src_i & model);
    chk("R9 low byte held", out_o[7:0], 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule